// File: doc/BRIEF.md
# Serial Link Port Status Controller

This block is the register-facing half of a byte-wide serial link port. A host reaches it over a small synchronous register bus and finds four registers there: a control register that holds four interrupt enables and a direct-wire mode bit, a status register with the link flags, a wire register for driving and sensing the two line wires by hand, and a data register that forwards outgoing bytes and returns the received byte. The bit-level serializer lives elsewhere. It meets this block through a byte handshake: `txValid`/`txData` with `txReady` on the transmit side, `rxValid`/`rxData` on the receive side, and two event pulses for line activity and line error.

The status register records transmit-free (bit 0), activity (bit 3), receive-full (bit 5), transmit-empty (bit 6) and error (bit 7). Bus accesses have side effects. Reading status returns its value and reloads it with 0x40. Writing data marks the transmit buffer as occupied. Reading data marks the receive buffer as empty. An interrupt request is raised while an enabled flag is set. Setting control bit 6 restarts the link and hands the wires to software. The wires are then driven with inverted polarity, and all link traffic and interrupts are held off.

Top module: `linkport_status_ctrl`

## Requirements
- R1: After reset the control register reads 0x00 and the status register reads 0x41. `txValid` and `irq` are low and `wireOut` is 2'b11.
- R2: A data write (select 3) stores the byte and clears status bit 0. The byte is presented on `txData`, and `txValid` is high from the next cycle whenever direct mode is off, including after direct mode is left.
- R3: A cycle with `txValid` and `txReady` both high hands the byte over. From the next cycle `txValid` is low and status bits 0 and 6 are set.
- R4: An `rxValid` pulse outside direct mode latches `rxData` and sets status bit 5. A data read returns the latched byte and clears bit 5. If a byte arrives in the same cycle as a data read, bit 5 stays set and the new byte is kept.
- R5: A status read (select 1) returns the current value, and the register becomes 0x40 on the next cycle. Events in the same cycle still set their bits on top of 0x40.
- R6: Outside direct mode, a `lineActivity` pulse sets status bit 3 and a `lineError` pulse sets status bit 7.
- R7: `irq` is high exactly when direct mode is off and one of these pairs holds: control bit 3 with status bit 7, control bit 2 with status bit 3, control bit 1 with status bit 6, or control bit 0 with status bit 5.
- R8: A control write with bit 6 set drops any pending transmit byte and sets status to 0x41. While control bit 6 is set, `irq` and `txValid` stay low, and `rxValid`, `lineActivity` and `lineError` are ignored. The receive byte and the status bits are left unchanged.
- R9: Outside direct mode `wireOut` is 2'b11. In direct mode `wireOut` is the inverse of wire register bits 1:0. A wire read (select 2) returns the stored bits 1:0, returns `wireIn` in bits 3:2 when in direct mode (zero otherwise), and returns zero in bits 7:4.
- R10: The register select codes are 0 for control, 1 for status, 2 for wire and 3 for data. The control register reads back all eight bits last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register select |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe; read side effects happen in this cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the cycle of `rdEn` |
| txValid | output | 1 | Transmit byte offered to the serializer |
| txReady | input | 1 | Serializer accepts the offered byte |
| txData | output | 8 | Byte to transmit |
| rxValid | input | 1 | Received byte present on `rxData` |
| rxData | input | 8 | Received byte |
| lineActivity | input | 1 | Line activity event pulse |
| lineError | input | 1 | Line error event pulse |
| wireIn | input | 2 | Sensed level of the two line wires |
| wireOut | output | 2 | Drive level of the two line wires |
| irq | output | 1 | Interrupt request |

## Verification
The checker holds on every cycle the properties that follow from a single strobe or event: a status read without other activity leaves 0x40, a data write leaves bit 0 clear, a handshake sets bits 0 and 6 and drops `txValid`, an arrival sets bit 5, direct mode keeps `irq` and `txValid` low, and the wires idle high outside direct mode. The bench scenarios cover what needs a history or exact values. These include the full status values after combined events, a read colliding with an arrival or an activity pulse, each interrupt enable paired with its own flag, and inputs ignored in direct mode shown later through status and data reads. They also cover the wire read with sensed levels and the retained transmit byte appearing once direct mode is left.

// File: rtl/linkport_pkg.sv
package linkport_pkg;

  localparam int REG_W  = 8;
  localparam int WIRE_W = 2;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_WIRE = 2'd2,
    SEL_DATA = 2'd3
  } regSel_e;

  localparam int ST_TXFREE  = 0;
  localparam int ST_ACT     = 3;
  localparam int ST_RXFULL  = 5;
  localparam int ST_TXEMPTY = 6;
  localparam int ST_ERR     = 7;

  localparam int CTRL_DIRECT = 6;
  localparam int EN_W        = 4;

  localparam logic [REG_W-1:0] STATUS_RESET  = 8'h41;
  localparam logic [REG_W-1:0] STATUS_RELOAD = 8'h40;

  typedef struct packed {
    logic wireWr;
    logic dataWr;
    logic statRd;
    logic dataRd;
    logic linkReset;
    logic txAccept;
    logic rxLatch;
    logic actSet;
    logic errSet;
  } strobes_t;

endpackage

// File: rtl/linkport_ctrl.sv
module linkport_ctrl
  import linkport_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] regSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             txReady,
  input  logic             rxValid,
  input  logic             lineActivity,
  input  logic             lineError,
  output logic [REG_W-1:0] ctrlReg,
  output logic             modeDirect,
  output logic             txValid,
  output strobes_t         stb
);

  logic txPending;
  logic selCtrl, selStat, selWire, selData;

  assign selCtrl = (regSel == SEL_CTRL);
  assign selStat = (regSel == SEL_STAT);
  assign selWire = (regSel == SEL_WIRE);
  assign selData = (regSel == SEL_DATA);

  assign modeDirect = ctrlReg[CTRL_DIRECT];
  assign txValid    = txPending && !modeDirect;

  always_comb begin
    stb           = '0;
    stb.wireWr    = wrEn && selWire;
    stb.dataWr    = wrEn && selData;
    stb.statRd    = rdEn && selStat;
    stb.dataRd    = rdEn && selData;
    stb.linkReset = wrEn && selCtrl && wrData[CTRL_DIRECT];
    stb.txAccept  = txValid && txReady;
    stb.rxLatch   = rxValid && !modeDirect;
    stb.actSet    = lineActivity && !modeDirect;
    stb.errSet    = lineError && !modeDirect;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (wrEn && selCtrl) begin
      ctrlReg <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPending <= 1'b0;
    end else if (stb.linkReset) begin
      txPending <= 1'b0;
    end else if (stb.dataWr) begin
      txPending <= 1'b1;
    end else if (stb.txAccept) begin
      txPending <= 1'b0;
    end
  end

endmodule

// File: rtl/linkport_dp.sv
module linkport_dp
  import linkport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [REG_W-1:0]  wrData,
  input  logic [REG_W-1:0]  ctrlReg,
  input  logic              modeDirect,
  input  logic [REG_W-1:0]  rxData,
  input  logic [WIRE_W-1:0] wireIn,
  output logic [REG_W-1:0]  rdData,
  output logic [REG_W-1:0]  txData,
  output logic [REG_W-1:0]  statusReg,
  output logic [WIRE_W-1:0] wireOut,
  output logic              irq
);

  localparam int WIRE_PAD = REG_W - 2*WIRE_W;

  logic [REG_W-1:0]  statusNext;
  logic [REG_W-1:0]  txBuf;
  logic [REG_W-1:0]  rxBuf;
  logic [WIRE_W-1:0] wireReg;
  logic [EN_W-1:0]   flagVec;

  always_comb begin
    statusNext = statusReg;
    if (stb.statRd)    statusNext = STATUS_RELOAD;
    if (stb.dataRd)    statusNext[ST_RXFULL] = 1'b0;
    if (stb.txAccept) begin
      statusNext[ST_TXFREE]  = 1'b1;
      statusNext[ST_TXEMPTY] = 1'b1;
    end
    if (stb.rxLatch)   statusNext[ST_RXFULL] = 1'b1;
    if (stb.actSet)    statusNext[ST_ACT]    = 1'b1;
    if (stb.errSet)    statusNext[ST_ERR]    = 1'b1;
    if (stb.dataWr)    statusNext[ST_TXFREE] = 1'b0;
    if (stb.linkReset) statusNext = STATUS_RESET;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= STATUS_RESET;
      txBuf     <= '0;
      rxBuf     <= '0;
      wireReg   <= '0;
    end else begin
      statusReg <= statusNext;
      if (stb.dataWr)  txBuf   <= wrData;
      if (stb.rxLatch) rxBuf   <= rxData;
      if (stb.wireWr)  wireReg <= wrData[WIRE_W-1:0];
    end
  end

  assign txData  = txBuf;
  assign wireOut = modeDirect ? ~wireReg : '1;

  assign flagVec = {statusReg[ST_ERR], statusReg[ST_ACT],
                    statusReg[ST_TXEMPTY], statusReg[ST_RXFULL]};
  assign irq     = !modeDirect && |(ctrlReg[EN_W-1:0] & flagVec);

  always_comb begin
    unique case (regSel)
      SEL_CTRL: rdData = ctrlReg;
      SEL_STAT: rdData = statusReg;
      SEL_WIRE: rdData = {{WIRE_PAD{1'b0}},
                          (modeDirect ? wireIn : {WIRE_W{1'b0}}), wireReg};
      default:  rdData = rxBuf;
    endcase
  end

endmodule

// File: rtl/linkport_status_ctrl.sv
module linkport_status_ctrl
  import linkport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              txValid,
  input  logic              txReady,
  output logic [REG_W-1:0]  txData,
  input  logic              rxValid,
  input  logic [REG_W-1:0]  rxData,
  input  logic              lineActivity,
  input  logic              lineError,
  input  logic [WIRE_W-1:0] wireIn,
  output logic [WIRE_W-1:0] wireOut,
  output logic              irq
);

  strobes_t         stb;
  logic [REG_W-1:0] ctrlReg;
  logic [REG_W-1:0] statusVal;
  logic             modeDirect;

  linkport_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .regSel       (regSel),
    .wrEn         (wrEn),
    .rdEn         (rdEn),
    .wrData       (wrData),
    .txReady      (txReady),
    .rxValid      (rxValid),
    .lineActivity (lineActivity),
    .lineError    (lineError),
    .ctrlReg      (ctrlReg),
    .modeDirect   (modeDirect),
    .txValid      (txValid),
    .stb          (stb)
  );

  linkport_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .regSel     (regSel),
    .wrData     (wrData),
    .ctrlReg    (ctrlReg),
    .modeDirect (modeDirect),
    .rxData     (rxData),
    .wireIn     (wireIn),
    .rdData     (rdData),
    .txData     (txData),
    .statusReg  (statusVal),
    .wireOut    (wireOut),
    .irq        (irq)
  );

endmodule

// File: rtl/linkport_checker.sv
module linkport_checker
  import linkport_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [SEL_W-1:0]  regSel,
  input logic              wrEn,
  input logic              rdEn,
  input logic [REG_W-1:0]  wrData,
  input logic              txValid,
  input logic              txReady,
  input logic              rxValid,
  input logic              lineActivity,
  input logic              lineError,
  input logic              irq,
  input logic [WIRE_W-1:0] wireOut,
  input logic              modeDirect,
  input logic [REG_W-1:0]  statusVal
);

  AST_STATUS_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel == SEL_STAT && !wrEn && !rxValid && !lineActivity &&
     !lineError && !(txValid && txReady)) |=> (statusVal == STATUS_RELOAD)); // R5

  AST_DATA_WR_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == SEL_DATA) |=> !statusVal[ST_TXFREE]); // R2

  AST_TX_HANDOFF: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && !wrEn && !rdEn) |=>
    (statusVal[ST_TXFREE] && statusVal[ST_TXEMPTY] && !txValid)); // R3

  AST_RX_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !modeDirect && !wrEn) |=> statusVal[ST_RXFULL]); // R4

  AST_DIRECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    modeDirect |-> (!irq && !txValid)); // R8

  AST_LINK_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == SEL_CTRL && wrData[CTRL_DIRECT]) |=>
    (statusVal == STATUS_RESET && modeDirect)); // R8

  AST_WIRE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !modeDirect |-> (wireOut == {WIRE_W{1'b1}})); // R9

endmodule

bind linkport_status_ctrl linkport_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regSel       (regSel),
  .wrEn         (wrEn),
  .rdEn         (rdEn),
  .wrData       (wrData),
  .txValid      (txValid),
  .txReady      (txReady),
  .rxValid      (rxValid),
  .lineActivity (lineActivity),
  .lineError    (lineError),
  .irq          (irq),
  .wireOut      (wireOut),
  .modeDirect   (modeDirect),
  .statusVal    (statusVal)
);

// File: tb/linkport_status_ctrl_test.sv
module linkport_status_ctrl_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       txValid;
  logic       txReady = 1'b0;
  logic [7:0] txData;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic       lineActivity = 1'b0;
  logic       lineError = 1'b0;
  logic [1:0] wireIn = 2'b00;
  logic [1:0] wireOut;
  logic       irq;

  int errCount = 0;
  int chkCount = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  localparam logic [1:0] CTRL = 2'd0, STAT = 2'd1, WIRE = 2'd2, DATA = 2'd3;

  always #10 clk = ~clk;

  linkport_status_ctrl uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .txValid(txValid), .txReady(txReady),
    .txData(txData), .rxValid(rxValid), .rxData(rxData),
    .lineActivity(lineActivity), .lineError(lineError),
    .wireIn(wireIn), .wireOut(wireOut), .irq(irq)
  );

  task automatic expect8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] sel, input logic [7:0] d);
    regSel = sel; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] sel, input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    regSel = sel; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulseReady();
    txReady = 1'b1; @(negedge clk); txReady = 1'b0;
  endtask

  task automatic pulseRx(input logic [7:0] d);
    rxData = d; rxValid = 1'b1; @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic pulseAct();
    lineActivity = 1'b1; @(negedge clk); lineActivity = 1'b0;
  endtask

  task automatic pulseErr();
    lineError = 1'b1; @(negedge clk); lineError = 1'b0;
  endtask

  // Monitor: pops the expected read value in the cycle the read strobe is up
  always @(negedge clk) begin
    #5;
    if (rdEn) begin
      if (expQ.size() == 0) begin
        chkCount++; errCount++;
        $display("FAIL R10: unexpected read got %h expected none", rdData);
      end else begin
        expect8(rdData, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  task automatic finishRun();
    chkCount++;
    if (expQ.size() != 0) begin
      errCount++;
      $display("FAIL R10: %0d reads not seen got 0 expected 0", expQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    chkCount++; errCount++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #5;
    expect8({7'd0, txValid}, 8'd0, "R1 txValid");
    expect8({7'd0, irq}, 8'd0, "R1 irq");
    expect8({6'd0, wireOut}, 8'h03, "R1 wireOut");
    @(negedge clk);
    busRead(CTRL, 8'h00, "R1 R10 ctrl reset");
    busRead(STAT, 8'h41, "R1 status reset");
    busRead(STAT, 8'h40, "R5 reload value");

    busWrite(DATA, 8'hA5);
    #5;
    expect8({7'd0, txValid}, 8'd1, "R2 txValid");
    expect8(txData, 8'hA5, "R2 txData");
    @(negedge clk);
    pulseReady();
    #5;
    expect8({7'd0, txValid}, 8'd0, "R3 txValid drop");
    @(negedge clk);
    busWrite(DATA, 8'h3C);
    busRead(STAT, 8'h40, "R2 bit0 cleared");
    #5;
    expect8(txData, 8'h3C, "R2 txData second");
    @(negedge clk);
    pulseReady();
    busRead(STAT, 8'h41, "R3 status after handoff");

    pulseRx(8'h77);
    busRead(DATA, 8'h77, "R4 rx byte");
    busRead(STAT, 8'h40, "R4 rxfull cleared");
    rxData = 8'h11; rxValid = 1'b1;
    busRead(DATA, 8'h77, "R4 read during arrival");
    rxValid = 1'b0;
    busRead(STAT, 8'h60, "R4 arrival wins");
    busRead(DATA, 8'h11, "R4 new byte kept");

    pulseAct();
    pulseErr();
    busRead(STAT, 8'hC8, "R6 activity and error");
    lineActivity = 1'b1;
    busRead(STAT, 8'h40, "R5 read with event");
    lineActivity = 1'b0;
    busRead(STAT, 8'h48, "R5 event survives reload");

    busWrite(CTRL, 8'hB5);
    busRead(CTRL, 8'hB5, "R10 ctrl readback");
    #5;
    expect8({7'd0, irq}, 8'd0, "R7 no flag");
    @(negedge clk);
    busWrite(CTRL, 8'h08);
    #5;
    expect8({7'd0, irq}, 8'd0, "R7 error not set");
    @(negedge clk);
    pulseErr();
    #5;
    expect8({7'd0, irq}, 8'd1, "R7 error enable");
    @(negedge clk);
    busWrite(CTRL, 8'h01);
    #5;
    expect8({7'd0, irq}, 8'd0, "R7 rx not set");
    @(negedge clk);
    pulseRx(8'h22);
    #5;
    expect8({7'd0, irq}, 8'd1, "R7 rx enable");
    @(negedge clk);
    busWrite(CTRL, 8'h02);
    #5;
    expect8({7'd0, irq}, 8'd1, "R7 tx-empty enable");
    @(negedge clk);

    busWrite(CTRL, 8'h42);
    #5;
    expect8({7'd0, irq}, 8'd0, "R8 irq held");
    expect8({7'd0, txValid}, 8'd0, "R8 txValid held");
    expect8({6'd0, wireOut}, 8'h03, "R9 direct wires from zero");
    @(negedge clk);
    busRead(STAT, 8'h41, "R8 link reset status");
    busWrite(WIRE, 8'hFD);
    #5;
    expect8({6'd0, wireOut}, 8'h02, "R9 inverted drive");
    @(negedge clk);
    wireIn = 2'b10;
    busRead(WIRE, 8'h09, "R9 wire readback");
    busWrite(DATA, 8'h99);
    #5;
    expect8({7'd0, txValid}, 8'd0, "R8 no tx in direct");
    @(negedge clk);
    pulseRx(8'h33);
    pulseAct();
    pulseErr();
    busRead(STAT, 8'h40, "R8 events ignored");
    busRead(DATA, 8'h22, "R8 rx byte unchanged");

    busWrite(CTRL, 8'h00);
    #5;
    expect8({6'd0, wireOut}, 8'h03, "R9 wires released");
    expect8({7'd0, txValid}, 8'd1, "R2 txValid after direct");
    expect8(txData, 8'h99, "R2 txData after direct");
    @(negedge clk);
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule